// File: doc/BRIEF.md
# Three-Channel Alarm Comparator with Periodic Rearm

This block watches a free-running 64-bit time count that is generated elsewhere and turns it into alarm events. Three identical channels all compare against that one count. Each channel holds a 64-bit target, written as two 32-bit words, and runs in either one-shot or periodic mode. A one-shot channel raises its event once, when the count reaches or passes the target. A periodic channel raises an event every P count units, where P is a 30-bit period and the first event is P units after the count value seen when the channel was armed.

Every event sets the channel's bit in a raw status vector. Software enables bits into the single interrupt line through a mask register and drops them through a write-one-to-clear register. Writes arrive on a simple one-cycle write strobe with a word address.

Each channel is a four-state machine:
- `CH_IDLE`: disarmed.
- `CH_ONESHOT_WAIT`: armed one-shot, waiting for its target.
- `CH_ONESHOT_SPENT`: one-shot has fired and is silent.
- `CH_PERIODIC_WAIT`: armed periodic, waiting for its next due value.

The transitions are:
- `arm_oneshot`: a control write with enable=1 and periodic=0 moves any state to `CH_ONESHOT_WAIT`.
- `arm_periodic`: a control write with enable=1 and periodic=1 moves any state to `CH_PERIODIC_WAIT` and loads the due value as count plus period.
- `disarm`: a control write with enable=0 moves any state to `CH_IDLE`.
- `oneshot_hit`: `CH_ONESHOT_WAIT` moves to `CH_ONESHOT_SPENT` when count ≥ target, unless the target is being written in that cycle.
- `target_rewrite`: a write to either target word moves `CH_ONESHOT_SPENT` back to `CH_ONESHOT_WAIT`.
- `periodic_hit`: `CH_PERIODIC_WAIT` stays put and advances its due value by the period when count ≥ due.

Top module: `alarm_cmp`

## Requirements
- R1: Channel n (n = 0..2) takes its target low word at address 4n, its target high word at address 4n+1 and its control word at address 4n+2. The comparison uses the full 64-bit target {high, low}, so a count that passes only the low word does not fire.
- R2: An armed one-shot channel sets raw bit n on the clock edge where the sampled count is greater than or equal to the target, including a count that jumps past the target.
- R3: After firing, a one-shot channel does not fire again until a target word is rewritten or its control word is rewritten with enable=1.
- R4: In control, bit 0 is enable and bit 1 selects periodic (1) or one-shot (0). A periodic channel armed while the sampled count is E sets raw bit n on the edges where the sampled count reaches E+P, then E+2P, and so on.
- R5: The period P is control bits 31:2, a 30-bit field whose full range up to 2^30-1 is kept without truncation.
- R6: The output irq_o is high exactly when some raw bit is set and its bit in the mask register is set. The mask register is at address 12, bits 2:0.
- R7: Writing address 13 clears each raw bit whose data bit (2:0) is 1. Data bits that are 0 leave their raw bits unchanged.
- R8: If a channel fires on the same edge that its clear bit is written, the raw bit ends up set.
- R9: Disarming a channel (enable=0) stops further events but leaves an already-set raw bit unchanged.
- R10: After reset, all raw bits and mask bits are 0, all channels are disarmed and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Live shared time count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| raw_o | output | 3 | Raw event status, bit n for channel n |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Several properties are checked on every cycle by the assertions:
- A firing one-shot is silent on the next cycle unless it is rewritten.
- A periodic due value steps by exactly the period after each hit, and arming loads count plus period.
- A disarm silences the channel at once.
- A raw bit never drops without a clear, and a fire on a clear edge still lands.

Other behaviour only the bench scenarios can show:
- The exact edge of each event against chosen count values.
- The full 64-bit compare when the count jumps across the high word.
- A 30-bit period kept across a jump of nearly 2^30 counts.
- Masking and unmasking as seen on the interrupt pin.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ONESHOT_WAIT,
        CH_ONESHOT_SPENT,
        CH_PERIODIC_WAIT
    } chan_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PER_BIT = 1;
    localparam int CTRL_PER_LO  = 2;

endpackage

// File: rtl/alarm_chan.sv
module alarm_chan
    import alarm_cmp_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wdata,
    output logic              fire
);

    localparam int PER_HI = CTRL_PER_LO + PERIOD_W - 1;
    localparam int HI_W   = CNT_W - WORD_W;

    chan_state_e         st_q, st_d;
    logic [CNT_W-1:0]    target_q;
    logic [CNT_W-1:0]    due_q;
    logic [PERIOD_W-1:0] period_q;
    logic [CNT_W-1:0]    wr_period_ext;
    logic [CNT_W-1:0]    period_ext;
    logic                tgt_wr;
    logic                arm;
    logic                arm_per;

    assign tgt_wr        = wr_lo | wr_hi;
    assign arm           = wr_ctrl & wdata[CTRL_EN_BIT];
    assign arm_per       = arm & wdata[CTRL_PER_BIT];
    assign wr_period_ext = {{(CNT_W-PERIOD_W){1'b0}}, wdata[PER_HI:CTRL_PER_LO]};
    assign period_ext    = {{(CNT_W-PERIOD_W){1'b0}}, period_q};

    // Output process: event decision for the current state
    always_comb begin
        unique case (st_q)
            CH_ONESHOT_WAIT:  fire = (count >= target_q);
            CH_PERIODIC_WAIT: fire = (count >= due_q);
            default:          fire = 1'b0;
        endcase
    end

    // Next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:          st_d = CH_IDLE;
            CH_ONESHOT_WAIT:  if (fire && !tgt_wr) st_d = CH_ONESHOT_SPENT;
            CH_ONESHOT_SPENT: if (tgt_wr) st_d = CH_ONESHOT_WAIT;
            CH_PERIODIC_WAIT: st_d = CH_PERIODIC_WAIT;
        endcase
        if (wr_ctrl) begin
            if (!wdata[CTRL_EN_BIT])      st_d = CH_IDLE;
            else if (wdata[CTRL_PER_BIT]) st_d = CH_PERIODIC_WAIT;
            else                          st_d = CH_ONESHOT_WAIT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // Target, period and due value registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            due_q    <= '0;
            period_q <= '0;
        end else begin
            if (wr_lo) target_q[WORD_W-1:0]     <= wdata;
            if (wr_hi) target_q[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
            if (wr_ctrl) period_q <= wdata[PER_HI:CTRL_PER_LO];
            if (arm_per)
                due_q <= count + wr_period_ext;
            else if (st_q == CH_PERIODIC_WAIT && fire)
                due_q <= due_q + period_ext;
        end
    end

    AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ONESHOT_WAIT && fire && !tgt_wr && !wr_ctrl) |=> !fire); // R3
    AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PERIODIC_WAIT && fire && !wr_ctrl) |=> (due_q == $past(due_q) + period_ext)); // R4
    AST_ARM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_per |=> (due_q == $past(count) + $past(wr_period_ext))); // R5
    AST_DISARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[CTRL_EN_BIT]) |=> !fire); // R9

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] raw,
    output logic              irq
);

    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | fire;
            if (mask_we) mask_q <= wdata;
        end
    end

    assign raw = raw_q;
    assign irq = |(raw_q & mask_q);

    AST_FIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((raw_q & $past(fire)) == $past(fire))); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(wdata & ~fire)) == '0)); // R7
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R9

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
    parameter int NUM_CH   = 3,
    parameter int CNT_W    = 64,
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 30,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic              irq_o
);

    localparam int STRIDE    = 4;
    localparam int MASK_ADDR = NUM_CH * STRIDE;
    localparam int CLR_ADDR  = MASK_ADDR + 1;

    logic [NUM_CH-1:0] fire;
    logic              mask_we;
    logic              clr_we;

    assign mask_we = wr_en_i && (wr_addr_i == ADDR_W'(MASK_ADDR));
    assign clr_we  = wr_en_i && (wr_addr_i == ADDR_W'(CLR_ADDR));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_lo, wr_hi, wr_ctrl;
        assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_W'(c*STRIDE));
        assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_W'(c*STRIDE + 1));
        assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(c*STRIDE + 2));

        alarm_chan #(
            .CNT_W    (CNT_W),
            .WORD_W   (WORD_W),
            .PERIOD_W (PERIOD_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (count_i),
            .wr_lo   (wr_lo),
            .wr_hi   (wr_hi),
            .wr_ctrl (wr_ctrl),
            .wdata   (wr_data_i),
            .fire    (fire[c])
        );
    end

    alarm_irq #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wdata   (wr_data_i[NUM_CH-1:0]),
        .raw     (raw_o),
        .irq     (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (raw_o == '0 && !irq_o)); // R10

endmodule

// File: tb/alarm_cmp_tb.sv
module alarm_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  raw;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic [2:0] raw;
        logic       irq;
        logic [7:0] req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    alarm_cmp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_i   (cnt),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .raw_o     (raw),
        .irq_o     (irq)
    );

    // Monitor: compare design outputs against queued expectations
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (raw !== e.raw || irq !== e.irq) begin
                n_err++;
                $display("FAIL R%0d: raw=%b irq=%b expected raw=%b irq=%b (count=%0h)",
                         e.req, raw, irq, e.raw, e.irq, cnt);
            end
        end
    end

    task automatic expect_out(input logic [2:0] r, input logic i, input int req);
        sb.push_back('{raw: r, irq: i, req: 8'(req)});
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cnt     = cnt + 1;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
    endtask

    task automatic idle();
        cyc(1'b0, 4'd0, 32'd0);
    endtask

    task automatic run_to(input logic [63:0] v);
        while (cnt != v) idle();
    endtask

    task automatic setcnt(input logic [63:0] v);
        @(posedge clk); #1;
        wr_en = 1'b0;
        cnt   = v;
    endtask

    initial begin
        logic [63:0] t, e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out(3'b000, 1'b0, 10);                       // R10 reset state

        // channel 0 one-shot at target 10
        cyc(1'b1, 4'd0, 32'd10);
        cyc(1'b1, 4'd1, 32'd0);
        cyc(1'b1, 4'd12, 32'd1);
        cyc(1'b1, 4'd2, 32'd1);
        run_to(64'd10);
        expect_out(3'b000, 1'b0, 2);                        // R2 not early
        idle();
        expect_out(3'b001, 1'b1, 2);                        // R2 fires at target
        repeat (3) idle();
        expect_out(3'b001, 1'b1, 3);
        cyc(1'b1, 4'd13, 32'd1);
        idle();
        expect_out(3'b000, 1'b0, 7);                        // R7 clear drops bit
        repeat (3) idle();
        expect_out(3'b000, 1'b0, 3);                        // R3 no refire
        t = cnt + 4;
        cyc(1'b1, 4'd0, t[31:0]);
        run_to(t);
        expect_out(3'b000, 1'b0, 3);
        idle();
        expect_out(3'b001, 1'b1, 3);                        // R3 refire after rewrite
        cyc(1'b1, 4'd13, 32'd0);
        idle();
        expect_out(3'b001, 1'b1, 7);                        // R7 zero bits ignored
        cyc(1'b1, 4'd13, 32'd1);
        idle();
        expect_out(3'b000, 1'b0, 7);

        // channel 1: full 64-bit target, mask off
        cyc(1'b1, 4'd4, 32'd0);
        cyc(1'b1, 4'd5, 32'd1);
        cyc(1'b1, 4'd6, 32'd1);
        repeat (3) idle();
        expect_out(3'b000, 1'b0, 1);                        // R1 low word alone no fire
        setcnt(64'h1_0000_0005);
        idle();
        expect_out(3'b010, 1'b0, 2);                        // R2 passed target; R6 masked
        cyc(1'b1, 4'd12, 32'd3);
        idle();
        expect_out(3'b010, 1'b1, 6);                        // R6 unmasked
        cyc(1'b1, 4'd13, 32'd2);
        idle();
        expect_out(3'b000, 1'b0, 7);

        // R8: fire and clear on the same edge
        cyc(1'b1, 4'd2, 32'd0);
        t = cnt + 8;
        cyc(1'b1, 4'd0, t[31:0]);
        cyc(1'b1, 4'd1, t[63:32]);
        cyc(1'b1, 4'd2, 32'd1);
        run_to(t - 1);
        cyc(1'b1, 4'd13, 32'd1);
        idle();
        expect_out(3'b001, 1'b1, 8);                        // R8 fire wins
        cyc(1'b1, 4'd13, 32'd1);
        idle();
        expect_out(3'b000, 1'b0, 8);

        // R4: periodic channel 2, period 6
        cyc(1'b1, 4'd12, 32'd7);
        cyc(1'b1, 4'd10, (32'd6 << 2) | 32'd3);
        e = cnt;
        run_to(e + 6);
        expect_out(3'b000, 1'b0, 4);
        idle();
        expect_out(3'b100, 1'b1, 4);                        // R4 first period
        cyc(1'b1, 4'd13, 32'd4);
        idle();
        expect_out(3'b000, 1'b0, 4);
        run_to(e + 12);
        expect_out(3'b000, 1'b0, 4);
        idle();
        expect_out(3'b100, 1'b1, 4);                        // R4 second period

        // R9: disarm keeps raw, no new events
        cyc(1'b1, 4'd10, 32'd0);
        idle();
        expect_out(3'b100, 1'b1, 9);
        cyc(1'b1, 4'd13, 32'd4);
        setcnt(cnt + 100);
        idle();
        idle();
        expect_out(3'b000, 1'b0, 9);                        // R9 silent after disarm

        // R5: full 30-bit period
        cyc(1'b1, 4'd10, 32'hFFFF_FFFF);
        e = cnt;
        setcnt(e + 64'h3FFF_FFFE);
        idle();
        expect_out(3'b000, 1'b0, 5);                        // R5 not early
        idle();
        expect_out(3'b100, 1'b1, 5);                        // R5 fires at 2^30-1

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule